// File: doc/BRIEF.md
# Dual-Mode Frequency Counter

This block measures an unknown digital input in one of two ways, both built on a single 16-bit saturating accumulator. In gated mode it counts rising edges of the input over a gate window. The window is a whole number of pulses of a 1 kHz reference enable, and the host picks a length between 1 ms and 10 s. In period mode it counts timebase pulses during one full period of the input. The timebase is the 10 MHz reference enable, optionally divided by ten or by one hundred.

The host starts a measurement with a start pulse. When the measurement completes, the block raises a ready flag and holds the count and an overflow flag until the host reads them. A read pulse acknowledges the result and also starts the next measurement. The mode and selections are captured when a measurement is launched. Scaling the count by the gate time and converting it to a frequency are left to the host.

Top module: `freq_counter`

## Requirements
- R1: After reset, `ready`, `result` and `overflow` are all zero. No measurement runs until `start` is pulsed, so `ready` stays low.
- R2: Gated mode (`mode_period`=0) works as follows:
  - The window opens on the first `tick_1k` pulse after launch and lasts G further `tick_1k` pulses.
  - The result is the number of low-to-high transitions of the input during the window, after a two-flop synchronizer. Each transition is counted once.
  - `gate_sel` sets G: code 0 gives 1, 1 gives 10, 2 gives 100, 3 gives 1000, and codes 4 to 7 give 10000.
- R3: Period mode (`mode_period`=1) starts counting on the first synchronized rising edge after launch. It counts timebase pulses up to and including the clock of the next rising edge. For a periodic input, the result equals the input period in timebase pulses.
- R4: `tb_sel` selects the timebase:
  - code 0: every `tick_10m` pulse;
  - code 1: every 10th pulse;
  - codes 2 and 3: every 100th pulse.
- R5: The accumulator never wraps. Past 0xFFFF it holds 0xFFFF, and the finished result then reports `overflow`=1. `overflow` is 1 only together with `result`=0xFFFF.
- R6: In period mode, 65536 timebase pulses without a completed period (waiting for either edge) end the measurement. The result is then 0xFFFF with `overflow`=1.
- R7: While `ready` is high and neither `start` nor `rd` is pulsed, `ready`, `result` and `overflow` hold regardless of input activity.
- R8: A `rd` pulse while `ready` is high clears `ready` and launches a new measurement with the current selections. A `rd` pulse while `ready` is low has no effect.
- R9: A `start` pulse in any state aborts the measurement in progress, clears `ready` and launches a new measurement.
- R10: `mode_period`, `gate_sel` and `tb_sel` are sampled at launch. Changes during a measurement do not affect it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_1k | input | 1 | 1 kHz reference enable, one clock wide |
| tick_10m | input | 1 | 10 MHz reference enable, one clock wide |
| sig_in | input | 1 | Unknown input, asynchronous |
| mode_period | input | 1 | 0 = gated edge count, 1 = period count |
| gate_sel | input | 3 | Gate length code |
| tb_sel | input | 2 | Timebase code |
| start | input | 1 | Launch a measurement |
| rd | input | 1 | Acknowledge result and relaunch |
| ready | output | 1 | Result valid and held |
| result | output | 16 | Accumulator value at completion |
| overflow | output | 1 | Count saturated or period timed out |

## Verification
The assertions check the following on every cycle:
- the accumulator holds at its ceiling and never wraps;
- overflow always coincides with an all-ones result;
- a synchronized rising edge lasts exactly one clock;
- the divider counters stay within their decade range;
- a held result is unchanged until the host acts;
- `start` always clears `ready`.

The count values themselves can only be shown by the bench's scenarios, because they depend on how the input, the reference enables and the gate length line up. These scenarios cover:
- the gate-code mapping and timebase division;
- the inclusive stop edge of period mode;
- the 65536-pulse timeout;
- abort by `start`, relaunch by `rd`, and capture of the selections at launch.

// File: rtl/fc_pkg.sv
package fc_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WAIT,
    ST_RUN,
    ST_HOLD
  } fc_state_e;

  // Number of 1 kHz ticks for a gate code: decades up to the top code.
  function automatic int unsigned fc_gate_ticks(input int unsigned code,
                                                input int unsigned top_code);
    int unsigned n;
    n = 1;
    for (int unsigned i = 0; i < 8; i++) begin
      if (i < code && i < top_code) n = n * 10;
    end
    return n;
  endfunction

endpackage

// File: rtl/fc_edge_sync.sv
module fc_edge_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_async,
  output logic rise
);

  logic [SYNC_STAGES:0] sh_q;

  always_ff @(posedge clk) begin
    if (rst) sh_q <= '0;
    else     sh_q <= {sh_q[SYNC_STAGES-1:0], d_async};
  end

  assign rise = sh_q[SYNC_STAGES-1] & ~sh_q[SYNC_STAGES];

  AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    rise |=> !rise); // R2

endmodule

// File: rtl/fc_timebase.sv
module fc_timebase #(
  parameter int STAGES = 2,
  parameter int DIV    = 10,
  parameter int SEL_W  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ref_pulse,
  input  logic [SEL_W-1:0] sel,
  output logic             tb_en
);

  localparam int CW = $clog2(DIV);

  logic [STAGES:0] en_chain;
  assign en_chain[0] = ref_pulse;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    logic [CW-1:0] cnt_q;
    logic          wrap;

    assign wrap = (cnt_q == CW'(DIV - 1));

    always_ff @(posedge clk) begin
      if (rst)              cnt_q <= '0;
      else if (en_chain[g]) cnt_q <= wrap ? '0 : cnt_q + 1'b1;
    end

    assign en_chain[g+1] = en_chain[g] & wrap;

    AST_TB_DIV_RANGE: assert property (@(posedge clk) disable iff (rst)
      cnt_q <= CW'(DIV - 1)); // R4
  end

  always_comb begin
    tb_en = en_chain[STAGES];
    for (int i = 0; i <= STAGES; i++) begin
      if (int'(sel) == i) tb_en = en_chain[i];
    end
  end

endmodule

// File: rtl/fc_sat_accum.sv
module fc_sat_accum #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         inc,
  output logic         at_max,
  output logic [W-1:0] nxt_cnt,
  output logic         nxt_sat
);

  logic [W-1:0] cnt_q;
  logic         sat_q;

  assign at_max  = (cnt_q == {W{1'b1}});
  assign nxt_cnt = (inc && !at_max) ? cnt_q + 1'b1 : cnt_q;
  assign nxt_sat = sat_q | (inc & at_max);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt_q <= '0;
      sat_q <= 1'b0;
    end else begin
      cnt_q <= nxt_cnt;
      sat_q <= nxt_sat;
    end
  end

  AST_ACC_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
    (at_max && !clr) |=> at_max); // R5
  AST_SAT_AT_MAX: assert property (@(posedge clk) disable iff (rst)
    sat_q |-> at_max); // R5

endmodule

// File: rtl/freq_counter.sv
module freq_counter
  import fc_pkg::*;
#(
  parameter int ACC_W         = 16,
  parameter int GATE_SEL_W    = 3,
  parameter int TB_SEL_W      = 2,
  parameter int GATE_TOP_CODE = 4,
  parameter int TB_STAGES     = 2,
  parameter int TB_DIV        = 10,
  parameter int SYNC_STAGES   = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  tick_1k,
  input  logic                  tick_10m,
  input  logic                  sig_in,
  input  logic                  mode_period,
  input  logic [GATE_SEL_W-1:0] gate_sel,
  input  logic [TB_SEL_W-1:0]   tb_sel,
  input  logic                  start,
  input  logic                  rd,
  output logic                  ready,
  output logic [ACC_W-1:0]      result,
  output logic                  overflow
);

  localparam int unsigned MAX_TICKS = fc_gate_ticks(GATE_TOP_CODE, GATE_TOP_CODE);
  localparam int          TICK_W    = $clog2(MAX_TICKS + 1);

  fc_state_e            state_q, state_d;
  logic                 period_q;
  logic [TB_SEL_W-1:0]  tb_q;
  logic [TICK_W-1:0]    gate_last_q, gate_last_d, tick_q;
  logic                 ready_q, ovf_q;
  logic [ACC_W-1:0]     result_q;

  logic                 rise, tb_en, launch, finish;
  logic                 acc_clr, acc_inc, at_max, nxt_sat;
  logic [ACC_W-1:0]     nxt_cnt;

  fc_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .d_async (sig_in),
    .rise    (rise)
  );

  fc_timebase #(.STAGES(TB_STAGES), .DIV(TB_DIV), .SEL_W(TB_SEL_W)) u_tb (
    .clk       (clk),
    .rst       (rst),
    .ref_pulse (tick_10m),
    .sel       (tb_q),
    .tb_en     (tb_en)
  );

  fc_sat_accum #(.W(ACC_W)) u_acc (
    .clk     (clk),
    .rst     (rst),
    .clr     (acc_clr),
    .inc     (acc_inc),
    .at_max  (at_max),
    .nxt_cnt (nxt_cnt),
    .nxt_sat (nxt_sat)
  );

  assign launch      = start | (rd & ready_q);
  assign gate_last_d = TICK_W'(fc_gate_ticks(int'(gate_sel), GATE_TOP_CODE) - 1);

  always_comb begin
    state_d = state_q;
    acc_clr = 1'b0;
    acc_inc = 1'b0;
    finish  = 1'b0;
    if (launch) begin
      state_d = ST_WAIT;
      acc_clr = 1'b1;
    end else begin
      case (state_q)
        ST_WAIT: begin
          if (!period_q) begin
            if (tick_1k) begin
              state_d = ST_RUN;
              acc_clr = 1'b1;
            end
          end else if (rise) begin
            state_d = ST_RUN;
            acc_clr = 1'b1;
          end else begin
            acc_inc = tb_en;
            finish  = tb_en & at_max;
          end
        end
        ST_RUN: begin
          if (!period_q) begin
            acc_inc = rise;
            finish  = tick_1k & (tick_q == gate_last_q);
          end else begin
            acc_inc = tb_en;
            finish  = rise | (tb_en & at_max);
          end
        end
        default: ;
      endcase
      if (finish) state_d = ST_HOLD;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      period_q    <= 1'b0;
      tb_q        <= '0;
      gate_last_q <= '0;
      tick_q      <= '0;
      ready_q     <= 1'b0;
      result_q    <= '0;
      ovf_q       <= 1'b0;
    end else begin
      state_q <= state_d;
      if (launch) begin
        period_q    <= mode_period;
        tb_q        <= tb_sel;
        gate_last_q <= gate_last_d;
        tick_q      <= '0;
        ready_q     <= 1'b0;
      end else begin
        if (state_q == ST_RUN && !period_q && tick_1k) tick_q <= tick_q + 1'b1;
        if (finish) begin
          ready_q  <= 1'b1;
          result_q <= nxt_cnt;
          ovf_q    <= nxt_sat;
        end
      end
    end
  end

  assign ready    = ready_q;
  assign result   = result_q;
  assign overflow = ovf_q;

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
    (ready_q && !start && !rd) |=> (ready_q && $stable(result_q) && $stable(ovf_q))); // R7
  AST_START_CLEARS_READY: assert property (@(posedge clk) disable iff (rst)
    start |=> !ready_q); // R9
  AST_OVF_ONLY_AT_MAX: assert property (@(posedge clk) disable iff (rst)
    ovf_q |-> (result_q == {ACC_W{1'b1}})); // R5

endmodule

// File: tb/freq_counter_tb.sv
module freq_counter_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick_1k = 1'b0, tick_10m = 1'b0, sig_in = 1'b0;
  logic        mode_period = 1'b0, start = 1'b0, rd = 1'b0;
  logic [2:0]  gate_sel = '0;
  logic [1:0]  tb_sel = '0;
  logic        ready, overflow;
  logic [15:0] result;

  int n_checks = 0;
  int n_fail   = 0;
  int tick_per = 20;
  int tb_per   = 1;
  int half     = 5;
  bit sig_run  = 1'b1;

  always #5 clk = ~clk;

  freq_counter u_dut (
    .clk(clk), .rst(rst), .tick_1k(tick_1k), .tick_10m(tick_10m),
    .sig_in(sig_in), .mode_period(mode_period), .gate_sel(gate_sel),
    .tb_sel(tb_sel), .start(start), .rd(rd), .ready(ready),
    .result(result), .overflow(overflow)
  );

  initial begin
    int k;
    k = 0;
    forever begin
      @(negedge clk);
      if (k >= tick_per - 1) begin k = 0; tick_1k = 1'b1; end
      else begin k++; tick_1k = 1'b0; end
    end
  end

  initial begin
    int k;
    k = 0;
    forever begin
      @(negedge clk);
      if (k >= tb_per - 1) begin k = 0; tick_10m = 1'b1; end
      else begin k++; tick_10m = 1'b0; end
    end
  end

  initial begin
    int k;
    k = 0;
    forever begin
      @(negedge clk);
      if (!sig_run) begin k = 0; sig_in = 1'b0; end
      else if (k >= half - 1) begin k = 0; sig_in = ~sig_in; end
      else k++;
    end
  end

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not finish (actual hung, expected done)");
    summary();
    $finish;
  end

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic pulse_start();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic pulse_rd();
    @(negedge clk) rd = 1'b1;
    @(negedge clk) rd = 1'b0;
  endtask

  task automatic wait_ready(input int limit, input string tag, output int cyc);
    cyc = 0;
    while (!ready && cyc < limit) begin
      @(negedge clk);
      cyc++;
    end
    check(ready, tag, ready, 1);
  endtask

  task automatic setup(input bit per, input int g, input int t, input int h);
    mode_period = per;
    gate_sel    = 3'(g);
    tb_sel      = 2'(t);
    half        = h;
    repeat (4 * h + 2 * tick_per + 4) @(negedge clk);
  endtask

  task automatic measure(input bit per, input int g, input int t, input int h,
                         input int exp, input string tag);
    int cyc;
    setup(per, g, t, h);
    pulse_start();
    wait_ready(60000, tag, cyc);
    check(result == 16'(exp), tag, result, exp);
    check(overflow == 1'b0, tag, overflow, 0);
  endtask

  task automatic t_reset();
    check(ready == 1'b0, "R1 ready", ready, 0);
    check(result == 16'd0, "R1 result", result, 0);
    check(overflow == 1'b0, "R1 overflow", overflow, 0);
    repeat (60) @(negedge clk);
    check(ready == 1'b0, "R1 idle without start", ready, 0);
  endtask

  task automatic t_gated();
    measure(1'b0, 0, 0, 5, 2, "R2 gate code 0");
    measure(1'b0, 1, 0, 5, 20, "R2 gate code 1");
    measure(1'b0, 2, 0, 20, 50, "R2 gate code 2");
    tick_per = 2;
    measure(1'b0, 3, 0, 50, 20, "R2 gate code 3");
    measure(1'b0, 4, 0, 50, 200, "R2 gate code 4");
    measure(1'b0, 7, 0, 50, 200, "R2 gate code 7");
    tick_per = 20;
  endtask

  task automatic t_hold();
    logic [15:0] r;
    r = result;
    repeat (200) @(negedge clk);
    check(ready == 1'b1, "R7 ready held", ready, 1);
    check(result == r, "R7 result held", result, r);
  endtask

  task automatic t_period();
    measure(1'b1, 0, 0, 100, 200, "R3 period tb code 0");
    measure(1'b1, 0, 1, 100, 20, "R4 tb code 1");
    measure(1'b1, 0, 2, 100, 2, "R4 tb code 2");
    measure(1'b1, 0, 3, 100, 2, "R4 tb code 3");
    tb_per = 2;
    measure(1'b1, 0, 0, 100, 100, "R3 slower reference");
    tb_per = 1;
  endtask

  task automatic t_read();
    int cyc;
    measure(1'b0, 0, 0, 5, 2, "R8 prior result");
    setup(1'b0, 1, 0, 5);
    pulse_rd();
    check(ready == 1'b0, "R8 rd clears ready", ready, 0);
    wait_ready(2000, "R8 relaunch", cyc);
    check(result == 16'd20, "R8 relaunch value", result, 20);
    setup(1'b0, 2, 0, 5);
    pulse_start();
    repeat (500) @(negedge clk);
    pulse_rd();
    check(ready == 1'b0, "R8 rd while busy ignored", ready, 0);
    wait_ready(4000, "R8 busy run ends", cyc);
    check(result == 16'd200, "R8 busy run value", result, 200);
  endtask

  task automatic t_abort();
    int cyc;
    setup(1'b0, 2, 0, 5);
    pulse_start();
    repeat (300) @(negedge clk);
    gate_sel = 3'd0;
    pulse_start();
    wait_ready(200, "R9 abort relaunch", cyc);
    check(cyc < 100, "R9 short gate used", cyc, 100);
    check(result == 16'd2, "R9 abort value", result, 2);
  endtask

  task automatic t_latch();
    int cyc;
    setup(1'b0, 1, 0, 5);
    pulse_start();
    repeat (10) @(negedge clk);
    gate_sel = 3'd2;
    mode_period = 1'b1;
    tb_sel = 2'd2;
    wait_ready(4000, "R10 latched config", cyc);
    check(result == 16'd20, "R10 latched value", result, 20);
  endtask

  task automatic t_timeout();
    int cyc;
    sig_run = 1'b0;
    setup(1'b1, 0, 0, 5);
    pulse_start();
    wait_ready(70000, "R6 timeout", cyc);
    check(cyc >= 65530 && cyc <= 65540, "R6 timeout length", cyc, 65535);
    check(result == 16'hFFFF, "R5 saturated result", result, 65535);
    check(overflow == 1'b1, "R6 overflow flag", overflow, 1);
    sig_run = 1'b1;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_gated();
    t_hold();
    t_period();
    t_read();
    t_abort();
    t_latch();
    t_timeout();
    summary();
    $finish;
  end

endmodule